// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time from seconds up to months in packed BCD. A small binary prescaler counts pulses on `osc_tick_i` and produces one internal seconds tick every 2^PRESC_W pulses. Seconds carry into minutes, minutes into hours, hours into day of month, and day of month into month. Software reads and writes each counter on its own through an 8-bit port with a 3-bit register select.

Mode and flag bits are held in the count registers. The hours register carries a 12/24-hour select and an AM/PM flag. The month register carries a leap flag, which decides whether February has 28 or 29 days. A write to the seconds register clears the upper prescaler stages, so software can realign the sub-second phase.

Register select values: 0 = seconds, 1 = minutes, 2 = hours, 3 = day of month, 4 = month. Values 5 to 7 are unused.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode, AM), day 0x01, month 0x01.
- R2: Seconds advance by one every 2^PRESC_W cycles in which `osc_tick_i` is high. Seconds and minutes count BCD 00 to 59. The 59→00 wrap of seconds advances minutes by one, and the 59→00 wrap of minutes advances hours by one.
- R3: Register layout:
  - seconds and minutes use bits [6:0];
  - hours uses bit 7 = PM, bit 6 = 12-hour mode, bits [5:0] = BCD hour;
  - day uses bits [5:0];
  - month uses bit 7 = leap flag, bits [4:0] = BCD month.
  Unused bits read 0. Selects 5 to 7 read 0x00, and writes to them change nothing.
- R4: In 24-hour mode (bit 6 = 0) the hours count 00 to 23. The 23→00 wrap advances the day.
- R5: In 12-hour mode (bit 6 = 1) the hours count 12, 01, ..., 11, 12. The day advances on the 11→12 step taken while PM = 1.
- R6: PM inverts on every 11→12 hour step. In 24-hour mode it also inverts on 23→00.
- R7: Day counts from 01 to the last day of the current month, then wraps to 01 and advances the month. The last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11.
- R8: For month 2 the last day is 29 when the leap flag is 1 and 28 when it is 0.
- R9: Month counts 01 to 12, then wraps to 01.
- R10: A write to seconds clears the top CLR_W prescaler stages. The next seconds tick then comes 2^PRESC_W minus the value of the kept low stages pulses later.
- R11: In a cycle with a write to a valid select, the seconds tick is dropped and only the written register changes.
- R12: The PM bit changes only by R6 or by a write. The mode bit and the leap flag change only by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | Sub-second pulse that feeds the prescaler |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
Every counter is visible at the read port, so a wrong carry or wrap shows up as a wrong register value in the cycle right after the tick that caused it. A wrong prescaler phase shows up as a seconds update that lands early or late by whole pulses. The bench sweeps every hour in both modes with both PM states, and every valid day of every month with the leap flag both clear and set. Each sweep step is checked one second after the counters are preset to just before a rollover.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DAY  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MON  = 3'd4;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_W = 4,
  parameter int CLR_W   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic realign_i,
  input  logic hold_i,
  output logic sec_tick_o
);
  localparam int KEEP_W = PRESC_W - CLR_W;
  localparam logic [PRESC_W-1:0] KEEP_MASK = (PRESC_W)'((1 << KEEP_W) - 1);

  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (realign_i)  cnt_q <= cnt_q & KEEP_MASK;
    else if (osc_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // a bus write in the same cycle swallows the tick
  assign sec_tick_o = osc_tick_i && (&cnt_q) && !hold_i;

  assert_realign_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i |=> cnt_q[PRESC_W-1 -: CLR_W] == '0);
endmodule

// File: rtl/rtc_mod60.sv
module rtc_mod60 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_pkg::*;
  logic [7:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (we_i)    val_q <= wdata_i & 8'h7F;
    else if (tick_i)  val_q <= (val_q == 8'h59) ? 8'h00 : bcd_inc(val_q);
  end

  assign carry_o = tick_i && (val_q == 8'h59);
  assign val_o   = val_q;

  assert_wrap_59_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_i && val_q == 8'h59) |=> val_q == 8'h00);
endmodule

// File: rtl/rtc_hour.sv
module rtc_hour (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] hour_o,
  output logic       carry_o
);
  import rtc_pkg::*;
  logic [7:0] hr_q, inc;
  logic [5:0] h, h_nxt;
  logic       pm, m12, flip, carry;

  assign h   = hr_q[5:0];
  assign pm  = hr_q[7];
  assign m12 = hr_q[6];
  assign inc = bcd_inc({2'b00, h});

  always_comb begin
    h_nxt = inc[5:0];
    flip  = (h == 6'h11);
    carry = 1'b0;
    if (m12) begin
      if (h == 6'h12) h_nxt = 6'h01;
      carry = (h == 6'h11) && pm;
    end else begin
      if (h == 6'h23) h_nxt = 6'h00;
      flip  = (h == 6'h11) || (h == 6'h23);
      carry = (h == 6'h23);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hr_q <= '0;
    else if (we_i)   hr_q <= wdata_i;
    else if (tick_i) hr_q <= {pm ^ flip, m12, h_nxt};
  end

  assign carry_o = tick_i && carry;
  assign hour_o  = hr_q;

  assert_mode_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(hr_q[6]));
  assert_pm_flip_24h_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_i && !m12 && h == 6'h23) |=> (hr_q[7] != $past(hr_q[7])) && hr_q[5:0] == 6'h00);
endmodule

// File: rtl/rtc_date.sv
module rtc_date (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       we_day_i,
  input  logic       we_mon_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] day_o,
  output logic [7:0] mon_o
);
  import rtc_pkg::*;
  logic [7:0] day_q, mon_q, day_inc, mon_inc;
  logic [5:0] last;
  logic       wrap;

  assign last    = last_day(mon_q[4:0], mon_q[7]);
  assign wrap    = (day_q[5:0] == last);
  assign day_inc = bcd_inc(day_q);
  assign mon_inc = bcd_inc(mon_q & 8'h1F);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_q <= 8'h01;
      mon_q <= 8'h01;
    end else begin
      if (we_day_i) day_q <= wdata_i & 8'h3F;
      if (we_mon_i) mon_q <= wdata_i & 8'h9F;
      if (tick_i && !we_day_i && !we_mon_i) begin
        day_q <= wrap ? 8'h01 : day_inc;
        if (wrap)
          mon_q <= {mon_q[7], 2'b00, (mon_q[4:0] == 5'h12) ? 5'h01 : mon_inc[4:0]};
      end
    end
  end

  assign day_o = day_q;
  assign mon_o = mon_q;

  assert_feb28_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_day_i && !we_mon_i && !mon_q[7] && mon_q[4:0] == 5'h02 && day_q == 8'h28)
    |=> day_q == 8'h01 && mon_q[4:0] == 5'h03);
  assert_dec_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_day_i && !we_mon_i && mon_q[4:0] == 5'h12 && day_q == 8'h31)
    |=> mon_q[4:0] == 5'h01 && mon_q[7] == $past(mon_q[7]));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int PRESC_W = 4,
  parameter int CLR_W   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  import rtc_pkg::*;

  logic       we_ok, sec_tick, hour_carry;
  logic [1:0] cnt_tick, cnt_carry;
  logic [7:0] cnt_val [2];
  logic [7:0] hour_val, day_val, mon_val;

  assign we_ok = we_i && (addr_i <= ADDR_MON);

  rtc_prescaler #(.PRESC_W(PRESC_W), .CLR_W(CLR_W)) u_presc (
    .clk_i, .rst_ni, .osc_tick_i,
    .realign_i (we_ok && addr_i == ADDR_SEC),
    .hold_i    (we_ok),
    .sec_tick_o(sec_tick)
  );

  assign cnt_tick = {cnt_carry[0], sec_tick};

  for (genvar g = 0; g < 2; g++) begin : g_ms
    rtc_mod60 u_cnt (
      .clk_i, .rst_ni,
      .tick_i (cnt_tick[g]),
      .we_i   (we_ok && addr_i == ADDR_W'(g)),
      .wdata_i,
      .val_o  (cnt_val[g]),
      .carry_o(cnt_carry[g])
    );
  end

  rtc_hour u_hour (
    .clk_i, .rst_ni,
    .tick_i (cnt_carry[1]),
    .we_i   (we_ok && addr_i == ADDR_HOUR),
    .wdata_i,
    .hour_o (hour_val),
    .carry_o(hour_carry)
  );

  rtc_date u_date (
    .clk_i, .rst_ni,
    .tick_i  (hour_carry),
    .we_day_i(we_ok && addr_i == ADDR_DAY),
    .we_mon_i(we_ok && addr_i == ADDR_MON),
    .wdata_i,
    .day_o   (day_val),
    .mon_o   (mon_val)
  );

  always_comb begin
    case (addr_i)
      ADDR_SEC:  rdata_o = cnt_val[0];
      ADDR_MIN:  rdata_o = cnt_val[1];
      ADDR_HOUR: rdata_o = hour_val;
      ADDR_DAY:  rdata_o = day_val;
      ADDR_MON:  rdata_o = mon_val;
      default:   rdata_o = 8'h00;
    endcase
  end

  assert_write_blocks_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_ok && addr_i != ADDR_SEC) |=> $stable(cnt_val[0]));
  assert_leap_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_ok && addr_i == ADDR_MON) |=> $stable(mon_val[7]));
endmodule

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  int pres = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar #(.PRESC_W(4), .CLR_W(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int dim(input int m, input int leap);
    if (m == 2) return leap ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 3'd0) pres = pres & 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc = 1'b1;
    end
    @(negedge clk);
    osc = 1'b0;
    pres = (pres + n) % 16;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] saved [5];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1 sec", 3'd0, 8'h00);
    chk_reg("R1 min", 3'd1, 8'h00);
    chk_reg("R1 hour", 3'd2, 8'h00);
    chk_reg("R1 day", 3'd3, 8'h01);
    chk_reg("R1 month", 3'd4, 8'h01);

    // R2 seconds/minutes sweep
    run(15);
    chk_reg("R2 no tick before 16 pulses", 3'd0, 8'h00);
    run(1);
    chk_reg("R2 first second", 3'd0, 8'h01);
    wr(3'd0, 8'h00);
    for (int s = 1; s <= 1200; s++) begin
      run(16);
      chk_reg("R2 sec", 3'd0, bcd(s % 60));
      chk_reg("R2 min", 3'd1, bcd(s / 60));
    end
    wr(3'd2, 8'h05); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    run(16);
    chk_reg("R2 min carry to hour", 3'd2, 8'h06);
    chk_reg("R2 min wrap", 3'd1, 8'h00);

    // R10 realign
    run(10);
    wr(3'd0, 8'h05);
    run(15);
    chk_reg("R10 held after realign", 3'd0, 8'h05);
    run(1);
    chk_reg("R10 tick after realign", 3'd0, 8'h06);
    run(5);
    wr(3'd0, 8'h20);
    run(14);
    chk_reg("R10 odd phase held", 3'd0, 8'h20);
    run(1);
    chk_reg("R10 odd phase tick", 3'd0, 8'h21);

    // R11 write beats tick
    run(15);
    @(negedge clk);
    osc = 1'b1; we = 1'b1; addr = 3'd1; wdata = 8'h42;
    @(negedge clk);
    osc = 1'b0; we = 1'b0;
    pres = 0;
    chk_reg("R11 sec unchanged", 3'd0, 8'h21);
    chk_reg("R11 min written", 3'd1, 8'h42);
    run(16);
    chk_reg("R11 next tick normal", 3'd0, 8'h22);

    // R4 R5 R6 R12 hours sweep
    for (int mode = 0; mode < 2; mode++) begin
      for (int pm = 0; pm < 2; pm++) begin
        for (int h = 0; h < 24; h++) begin
          int nh, npm, carry;
          if (mode == 1 && (h < 1 || h > 12)) continue;
          if (mode == 0) begin
            nh = (h == 23) ? 0 : h + 1;
            npm = (h == 11 || h == 23) ? 1 - pm : pm;
            carry = (h == 23);
          end else begin
            nh = (h == 12) ? 1 : h + 1;
            npm = (h == 11) ? 1 - pm : pm;
            carry = (h == 11 && pm == 1);
          end
          wr(3'd4, 8'h03); wr(3'd3, 8'h10);
          wr(3'd2, 8'(pm * 128 + mode * 64) | bcd(h));
          wr(3'd1, 8'h59); wr(3'd0, 8'h59);
          run(16);
          chk_reg(mode ? "R5 R6 R12 hour 12h" : "R4 R6 R12 hour 24h", 3'd2,
                  8'(npm * 128 + mode * 64) | bcd(nh));
          chk_reg(mode ? "R5 day carry 12h" : "R4 day carry 24h", 3'd3, carry ? 8'h11 : 8'h10);
        end
      end
    end

    // R7 R8 R9 R12 calendar sweep
    for (int leap = 0; leap < 2; leap++) begin
      for (int m = 1; m <= 12; m++) begin
        for (int d = 1; d <= dim(m, leap); d++) begin
          int nd, nm;
          nd = (d == dim(m, leap)) ? 1 : d + 1;
          nm = (d == dim(m, leap)) ? ((m == 12) ? 1 : m + 1) : m;
          wr(3'd4, 8'(leap * 128) | bcd(m));
          wr(3'd3, bcd(d));
          wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
          run(16);
          chk_reg(m == 2 ? "R8 day" : "R7 day", 3'd3, bcd(nd));
          chk_reg(m == 12 ? "R9 R12 month" : "R7 R12 month", 3'd4, 8'(leap * 128) | bcd(nm));
          chk_reg("R6 pm flip at day change", 3'd2, 8'h80);
        end
      end
    end

    // R3 layout, unused bits, unused selects
    wr(3'd3, 8'hC5);
    chk_reg("R3 day mask", 3'd3, 8'h05);
    wr(3'd4, 8'hE9);
    chk_reg("R3 month mask", 3'd4, 8'h89);
    wr(3'd2, 8'hD1);
    chk_reg("R3 hour all bits", 3'd2, 8'hD1);
    wr(3'd1, 8'hB3);
    chk_reg("R3 min mask", 3'd1, 8'h33);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      saved[a] = v;
    end
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    for (int a = 0; a < 5; a++) chk_reg("R3 unused select write ignored", 3'(a), saved[a]);
    chk_reg("R3 unused select reads 0", 3'd5, 8'h00);
    chk_reg("R3 unused select reads 0", 3'd7, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule